// File: doc/BRIEF.md
# Vector Table Error Status and Fallback Steering

This block sits next to an interrupt vector table that is protected by a single-error-correct, double-error-detect code. An external decoder checks each table lookup and raises strobes. One strobe means a single-bit error was found and corrected. The other means a double-bit error was found and could not be corrected. The block stores each kind of event in a sticky flag inside a 32-bit status word. It also chooses which value goes out on the vector output.

While the uncorrectable flag is clear, the vector output follows the (already corrected) table word. The lookup that detects an uncorrectable error returns the fallback vector at once, and so does every lookup after it. The fallback vector comes from a separate register outside this block. Table words are used again only after software clears the flag.

Software reaches the status word through a synchronous register port. The port has an address, a write enable, write data, a privilege input and registered read data. A flag is cleared by a privileged write of 1 to its bit. Writes of 0 and user-mode writes do nothing.

Top module: `vececc_guard`

## Requirements
- R1: After a synchronous reset, both flags are 0 and a read of the status word at offset 0xEC returns 0.
- R2: A lookup (`lkp_valid`=1) with `lkp_sbe`=1 sets the corrected-error flag in status bit 8 at the next clock edge. While the uncorrectable flag is clear, the vector output equals `tbl_word`.
- R3: A lookup with `lkp_dbe`=1 sets the uncorrectable flag in status bit 0 at the next clock edge. In that same lookup cycle, `vec_out` already equals `fb_vec`.
- R4: While status bit 0 is 1, `vec_out` equals `fb_vec` for every lookup, whatever the strobes and table word are.
- R5: A write with `reg_priv`=1 to offset 0xEC clears each flag whose bit in the write data is 1. Once bit 0 is cleared, `vec_out` follows `tbl_word` again.
- R6: A write with `reg_priv`=0, and a privileged write of 0 to a flag bit, leave both flags unchanged.
- R7: Status bits 31..9 and 7..1 always read 0, and writes to them have no effect.
- R8: A read at any address other than 0xEC returns 0, and a write there does not change the flags.
- R9: Both flags are sticky. If a set event and a privileged clear of the same flag arrive in the same cycle, the flag ends set.
- R10: Error strobes that arrive while `lkp_valid`=0 do not set any flag.
- R11: `reg_rdata` is registered. It shows the status word as it stood at the clock edge at which the address was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | A vector table lookup is in progress this cycle |
| lkp_sbe | input | 1 | Decoder found and corrected a single-bit error |
| lkp_dbe | input | 1 | Decoder found an uncorrectable double-bit error |
| tbl_word | input | VEC_W | Corrected word read from the vector table |
| fb_vec | input | VEC_W | Fallback vector from an external register |
| vec_out | output | VEC_W | Vector delivered for the lookup |
| reg_addr | input | ADDR_W | Register byte address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_priv | input | 1 | Access is made in privileged mode |
| reg_rdata | output | 32 | Registered read data |

## Verification
The bench builds the block with its default parameters: a 32-bit vector, a 10-bit address and the status word at 0xEC. In most lookups the fallback vector is the bitwise inverse of the table word. A stuck or crossed bit anywhere on the output mux therefore shows up as a mismatch. The 10-bit address gives room for a neighbouring address (0xF0) and for an alias that differs only above bit 7 (0x1EC). Both are used to show that decoding uses every address bit. The bench also holds a set strobe and a privileged clear in the same cycle to check that the set wins.

// File: rtl/vececc_pkg.sv
package vececc_pkg;
  localparam int STAT_W    = 32;
  localparam int CORR_POS  = 8;
  localparam int FATAL_POS = 0;
  localparam logic [STAT_W-1:0] STAT_MASK =
    (STAT_W'(1) << CORR_POS) | (STAT_W'(1) << FATAL_POS);

  typedef struct packed {
    logic corr;
    logic fatal;
  } evt_t;
endpackage

// File: rtl/vececc_evt.sv
module vececc_evt
  import vececc_pkg::*;
(
  input  logic              lkp_valid,
  input  logic              lkp_sbe,
  input  logic              lkp_dbe,
  output evt_t              evt,
  output logic [STAT_W-1:0] set_word
);
  always_comb begin
    evt.corr  = lkp_valid & lkp_sbe;
    evt.fatal = lkp_valid & lkp_dbe;
    set_word  = '0;
    set_word[CORR_POS]  = evt.corr;
    set_word[FATAL_POS] = evt.fatal;
  end
endmodule

// File: rtl/vececc_regport.sv
module vececc_regport
  import vececc_pkg::*;
#(
  parameter int               ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(12'h0EC)
) (
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [STAT_W-1:0] reg_wdata,
  input  logic              reg_priv,
  output logic              hit,
  output logic [STAT_W-1:0] clr_word
);
  always_comb begin
    hit      = (reg_addr == STAT_OFS);
    clr_word = (hit && reg_we && reg_priv) ? reg_wdata : '0;
  end
endmodule

// File: rtl/vececc_status.sv
module vececc_status
  import vececc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] set_word,
  input  logic [STAT_W-1:0] clr_word,
  output logic [STAT_W-1:0] stat_q
);
  logic [STAT_W-1:0] stat_nxt;

  // Clear first, then set: a set event in the same cycle survives a clear.
  always_comb stat_nxt = ((stat_q & ~clr_word) | set_word) & STAT_MASK;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_nxt;
  end
endmodule

// File: rtl/vececc_vsel.sv
module vececc_vsel #(
  parameter int VEC_W = 32
) (
  input  logic             fatal_q,
  input  logic             fatal_now,
  input  logic [VEC_W-1:0] tbl_word,
  input  logic [VEC_W-1:0] fb_vec,
  output logic [VEC_W-1:0] vec_out
);
  always_comb vec_out = (fatal_q || fatal_now) ? fb_vec : tbl_word;
endmodule

// File: rtl/vececc_guard.sv
module vececc_guard
  import vececc_pkg::*;
#(
  parameter int                VEC_W    = 32,
  parameter int                ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(12'h0EC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lkp_valid,
  input  logic              lkp_sbe,
  input  logic              lkp_dbe,
  input  logic [VEC_W-1:0]  tbl_word,
  input  logic [VEC_W-1:0]  fb_vec,
  output logic [VEC_W-1:0]  vec_out,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_priv,
  output logic [31:0]       reg_rdata
);
  evt_t              evt;
  logic [STAT_W-1:0] set_word;
  logic [STAT_W-1:0] clr_word;
  logic [STAT_W-1:0] stat_q;
  logic              hit;

  vececc_evt u_evt (
    .lkp_valid (lkp_valid),
    .lkp_sbe   (lkp_sbe),
    .lkp_dbe   (lkp_dbe),
    .evt       (evt),
    .set_word  (set_word)
  );

  vececc_regport #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS)) u_port (
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_priv  (reg_priv),
    .hit       (hit),
    .clr_word  (clr_word)
  );

  vececc_status u_stat (
    .clk      (clk),
    .rst      (rst),
    .set_word (set_word),
    .clr_word (clr_word),
    .stat_q   (stat_q)
  );

  vececc_vsel #(.VEC_W(VEC_W)) u_vsel (
    .fatal_q   (stat_q[FATAL_POS]),
    .fatal_now (evt.fatal),
    .tbl_word  (tbl_word),
    .fb_vec    (fb_vec),
    .vec_out   (vec_out)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= hit ? stat_q : '0;
  end
endmodule

// File: rtl/vececc_guard_chk.sv
module vececc_guard_chk #(
  parameter int                VEC_W    = 32,
  parameter int                ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(12'h0EC)
) (
  input logic              clk,
  input logic              rst,
  input logic              lkp_valid,
  input logic              lkp_sbe,
  input logic              lkp_dbe,
  input logic [VEC_W-1:0]  tbl_word,
  input logic [VEC_W-1:0]  fb_vec,
  input logic [VEC_W-1:0]  vec_out,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [31:0]       reg_wdata,
  input logic              reg_priv,
  input logic [31:0]       reg_rdata,
  input logic [31:0]       stat
);
  p_corr_set_r2: assert property (@(posedge clk) disable iff (rst)
    (lkp_valid && lkp_sbe) |=> stat[8]);

  p_table_path_r2: assert property (@(posedge clk) disable iff (rst)
    (!stat[0] && !(lkp_valid && lkp_dbe)) |-> (vec_out == tbl_word));

  p_fatal_set_r3: assert property (@(posedge clk) disable iff (rst)
    (lkp_valid && lkp_dbe) |=> stat[0]);

  p_fallback_r4: assert property (@(posedge clk) disable iff (rst)
    stat[0] |-> (vec_out == fb_vec));

  p_priv_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_priv && reg_addr == STAT_OFS && reg_wdata[0]
     && !(lkp_valid && lkp_dbe)) |=> !stat[0]);

  p_user_noclr_r6: assert property (@(posedge clk) disable iff (rst)
    (!reg_priv && stat[0]) |=> stat[0]);

  p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & 32'hFFFF_FEFE) == 32'h0);

  p_other_addr_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_addr != STAT_OFS && stat[8]) |=> stat[8]);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (lkp_valid && lkp_dbe && reg_we && reg_priv) |=> stat[0]);

  p_no_valid_r10: assert property (@(posedge clk) disable iff (rst)
    (!lkp_valid && !stat[8]) |=> !stat[8]);
endmodule

bind vececc_guard vececc_guard_chk #(
  .VEC_W(VEC_W), .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lkp_valid (lkp_valid),
  .lkp_sbe   (lkp_sbe),
  .lkp_dbe   (lkp_dbe),
  .tbl_word  (tbl_word),
  .fb_vec    (fb_vec),
  .vec_out   (vec_out),
  .reg_addr  (reg_addr),
  .reg_we    (reg_we),
  .reg_wdata (reg_wdata),
  .reg_priv  (reg_priv),
  .reg_rdata (reg_rdata),
  .stat      (stat_q)
);

// File: tb/vececc_guard_tb.sv
`timescale 1ns/1ps
module vececc_guard_tb;
  localparam int VEC_W  = 32;
  localparam int ADDR_W = 10;
  localparam logic [ADDR_W-1:0] OFS = 10'h0EC;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              lkp_valid = 1'b0, lkp_sbe = 1'b0, lkp_dbe = 1'b0;
  logic [VEC_W-1:0]  tbl_word = '0, fb_vec = '0;
  logic [VEC_W-1:0]  vec_out;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic              reg_we = 1'b0, reg_priv = 1'b0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;

  int unsigned n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vececc_guard u_dut (
    .clk(clk), .rst(rst), .lkp_valid(lkp_valid), .lkp_sbe(lkp_sbe),
    .lkp_dbe(lkp_dbe), .tbl_word(tbl_word), .fb_vec(fb_vec), .vec_out(vec_out),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_priv(reg_priv), .reg_rdata(reg_rdata)
  );

  typedef struct packed {
    logic        v;
    logic        s;
    logic        d;
    logic [31:0] tw;
    logic [31:0] fb;
    logic        use_fb;
  } tv_t;

  // Lookup walk: R2 table path, R3 same-cycle fallback, R4 latched fallback.
  localparam tv_t TV [8] = '{
    '{1'b1, 1'b0, 1'b0, 32'h1234_5678, 32'hEDCB_A987, 1'b0},
    '{1'b1, 1'b1, 1'b0, 32'h0000_0040, 32'hFFFF_FFBF, 1'b0},
    '{1'b1, 1'b0, 1'b0, 32'hA5A5_5A5A, 32'h5A5A_A5A5, 1'b0},
    '{1'b1, 1'b0, 1'b1, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 32'h8000_0001, 32'h7FFF_FFFE, 1'b1},
    '{1'b1, 1'b1, 1'b0, 32'h3C3C_C3C3, 32'hC3C3_3C3C, 1'b1},
    '{1'b0, 1'b0, 1'b0, 32'hFFFF_0000, 32'h0000_FFFF, 1'b1},
    '{1'b1, 1'b1, 1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic v, input logic s, input logic d,
                        input logic [31:0] tw, input logic [31:0] fb,
                        input logic [31:0] exp, input string tag);
    @(negedge clk);
    lkp_valid = v; lkp_sbe = s; lkp_dbe = d; tbl_word = tw; fb_vec = fb;
    #1 chk(tag, vec_out, exp);
    @(posedge clk);
    #1 lkp_valid = 1'b0; lkp_sbe = 1'b0; lkp_dbe = 1'b0;
  endtask

  task automatic reg_wr(input logic [ADDR_W-1:0] a, input logic [31:0] dat, input logic p);
    @(negedge clk);
    reg_addr = a; reg_wdata = dat; reg_priv = p; reg_we = 1'b1;
    @(posedge clk);
    #1 reg_we = 1'b0; reg_priv = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1 chk(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    chk("R1 rdata after reset", reg_rdata, 32'h0);
    reg_rd(OFS, 32'h0, "R1 status after reset");

    // R10: strobes without a lookup
    @(negedge clk); lkp_sbe = 1'b1; lkp_dbe = 1'b1;
    @(posedge clk); #1 lkp_sbe = 1'b0; lkp_dbe = 1'b0;
    reg_rd(OFS, 32'h0, "R10 strobes without valid");

    for (int i = 0; i < 8; i++) begin
      lookup(TV[i].v, TV[i].s, TV[i].d, TV[i].tw, TV[i].fb,
             TV[i].use_fb ? TV[i].fb : TV[i].tw, $sformatf("R2/R3/R4 vector %0d", i));
    end
    reg_rd(OFS, 32'h0000_0101, "R2 R3 both flags set");

    // R11: read returns the word as of the sampling edge
    @(negedge clk); reg_addr = OFS; reg_we = 1'b1; reg_priv = 1'b1; reg_wdata = 32'h1;
    @(posedge clk); #1 reg_we = 1'b0; reg_priv = 1'b0;
    chk("R11 read shows pre-clear word", reg_rdata, 32'h0000_0101);
    reg_rd(OFS, 32'h0000_0100, "R11 next read shows cleared bit");
    lookup(1'b1, 1'b1, 1'b1, 32'h0, 32'h0, 32'h0, "R3 relatch");

    reg_wr(OFS, 32'hFFFF_FFFF, 1'b0);
    reg_rd(OFS, 32'h0000_0101, "R6 user write of ones");
    reg_wr(OFS, 32'h0, 1'b1);
    reg_rd(OFS, 32'h0000_0101, "R6 privileged write of zeros");
    reg_wr(10'h0F0, 32'hFFFF_FFFF, 1'b1);
    reg_rd(OFS, 32'h0000_0101, "R8 write elsewhere");
    reg_rd(10'h0F0, 32'h0, "R8 read elsewhere");
    reg_wr(10'h1EC, 32'hFFFF_FFFF, 1'b1);
    reg_rd(10'h1EC, 32'h0, "R8 alias read");
    reg_rd(OFS, 32'h0000_0101, "R8 alias write");

    reg_wr(OFS, 32'h0000_0100, 1'b1);
    reg_rd(OFS, 32'h0000_0001, "R5 clear corrected flag");
    lookup(1'b1, 1'b0, 1'b0, 32'h1111_2222, 32'h3333_4444, 32'h3333_4444, "R4 still fallback");
    reg_wr(OFS, 32'h0000_0001, 1'b1);
    reg_rd(OFS, 32'h0, "R5 clear fatal flag");
    lookup(1'b1, 1'b0, 1'b0, 32'h1111_2222, 32'h3333_4444, 32'h1111_2222, "R5 table after clear");

    reg_wr(OFS, 32'hFFFF_FEFE, 1'b1);
    reg_rd(OFS, 32'h0, "R7 reserved write");

    // R9: set and clear in the same cycle
    @(negedge clk);
    lkp_valid = 1'b1; lkp_dbe = 1'b1; lkp_sbe = 1'b1;
    reg_addr = OFS; reg_we = 1'b1; reg_priv = 1'b1; reg_wdata = 32'h0000_0101;
    @(posedge clk); #1
    lkp_valid = 1'b0; lkp_dbe = 1'b0; lkp_sbe = 1'b0; reg_we = 1'b0; reg_priv = 1'b0;
    reg_rd(OFS, 32'h0000_0101, "R9 set wins over clear");

    // R1: reset mid-run
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    reg_rd(OFS, 32'h0, "R1 status after mid-run reset");
    lookup(1'b1, 1'b0, 1'b0, 32'hCAFE_0001, 32'h0BAD_0002, 32'hCAFE_0001, "R1 table after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule